// File: doc/BRIEF.md
# Vectored Interrupt Entry Sequencer

This block is the trap-entry and acknowledge logic of a small machine-mode processor core. An external interrupt controller raises a request and presents the address of the handler that should run. When machine interrupts are enabled, the sequencer takes the interrupt. It saves the interrupted program counter, updates the interrupt status and cause registers, and redirects the fetch stream. It also reports three kinds of handling event back to the controller through a 2-bit acknowledge code. These events are entering a handler, returning from one, and software enabling interrupts again. The controller uses these codes to retire edge and level requests correctly.

A build parameter picks the redirect target. In vectored mode, the core jumps straight to the address the controller supplies. In common-vector mode, it jumps to the trap-vector base and records the external-interrupt cause. A second parameter says whether the core has an MMU. This decides the value saved as the previous privilege level.

The instruction pipeline, memory system, controller priority logic and general CSR decoding are outside this block. The pipeline is represented by the current PC, the current privilege level, a return-instruction strobe and a write strobe for the interrupt-enable bit.

Top module: `irq_entry_seq`

## Requirements
- R1: An interrupt is taken only on a clock edge where `irq_req` is 1 and `mie_o` is 1. A request while `mie_o` is 0 changes no output.
- R2: On taking an interrupt, `mepc_o` is loaded with `pc_in`. In the following cycle, `redirect_valid` is 1 for one cycle.
- R3: With VECTORED=1, the redirect target is the `irq_handler_addr` sampled at the taking edge, and `mcause_o` is left unchanged.
- R4: With VECTORED=0, the redirect target is `mtvec_in`, and `mcause_o` becomes 0x8000000B (top bit set for interrupt, code 11 for machine external).
- R5: On taking an interrupt, `mpie_o` takes the old `mie_o`, `mie_o` becomes 0, `mtval_o` becomes 0, and `resv_clear` pulses 1 for one cycle.
- R6: On taking an interrupt, `mpp_o` becomes 2'b11 when HAS_MMU=0, and becomes `priv_in` when HAS_MMU=1.
- R7: `irq_ack` is 2'b01 in the cycle after the taking edge, which is the same cycle as the redirect.
- R8: On `mret_fire`, `mie_o` takes `mpie_o` and `mpie_o` becomes 1. The redirect goes to the old `mepc_o`, and `irq_ack` is 2'b10 in the next cycle. This holds even when the restore raises `mie_o`.
- R9: On `csr_write_mie`, `mie_o` takes `csr_mie_value`. `irq_ack` is 2'b11 in the next cycle only if `mie_o` went from 0 to 1; otherwise it stays 2'b00.
- R10: Within one cycle, interrupt entry beats `mret_fire`, and `mret_fire` beats `csr_write_mie`. A losing event has no effect.
- R11: `irq_ack` is non-zero for exactly the one cycle following each event and is 2'b00 in every cycle with no event.
- R12: Synchronous reset sets `mie_o`, `mpie_o`, `mepc_o`, `mcause_o`, `mtval_o`, `irq_ack`, `redirect_valid` and `resv_clear` to 0, and sets `mpp_o` to 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | 1 | Interrupt request from the controller |
| irq_handler_addr | input | XLEN | Handler address from the controller |
| pc_in | input | XLEN | PC of the instruction being interrupted |
| priv_in | input | 2 | Current privilege level |
| mtvec_in | input | XLEN | Trap-vector base address |
| mret_fire | input | 1 | Return-from-trap instruction executes |
| csr_write_mie | input | 1 | Software writes the interrupt-enable bit |
| csr_mie_value | input | 1 | Value written to the interrupt-enable bit |
| redirect_valid | output | 1 | Fetch redirect strobe |
| redirect_pc | output | XLEN | Fetch redirect target |
| irq_ack | output | 2 | Acknowledge code: 00 none, 01 entry, 10 return, 11 re-enable |
| mie_o | output | 1 | Machine interrupt enable |
| mpie_o | output | 1 | Previous interrupt enable |
| mpp_o | output | 2 | Previous privilege level |
| mepc_o | output | XLEN | Saved exception PC |
| mcause_o | output | XLEN | Trap cause |
| mtval_o | output | XLEN | Trap value |
| resv_clear | output | 1 | Cancels a load-reserved reservation |

## Verification
Two instances run from the same stimulus: one vectored without an MMU, and one common-vector with an MMU. A redirect that matches only one of the handler address and the trap base therefore exposes a swapped mode. Requests are applied with interrupts both disabled and enabled, so the gating is seen from both sides. Return instructions are applied both directly after reset (previous-enable 0) and after an entry (previous-enable 1). Enable writes are applied both when the bit was clear and when it was already set. A handful of cycles carry two or three events at once, which fixes the priority order and shows that the losing event leaves no trace. An enable write followed directly by a request checks that a re-enable code can be followed at once by an entry code.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

    typedef enum logic [1:0] {
        ACK_IDLE     = 2'b00,
        ACK_ENTER    = 2'b01,
        ACK_RETURN   = 2'b10,
        ACK_REENABLE = 2'b11
    } ack_code_e;

    typedef enum logic [1:0] {
        EV_NONE,
        EV_TAKE,
        EV_MRET,
        EV_CSR
    } trap_event_e;

    typedef struct packed {
        trap_event_e ev;
        logic        reenable;
        logic        new_mie;
    } evt_t;

    localparam logic [1:0] PRIV_MACHINE    = 2'b11;
    localparam logic [4:0] CAUSE_CODE_MEXT = 5'd11;

    function automatic ack_code_e ack_for_event(evt_t e);
        ack_code_e code;
        case (e.ev)
            EV_TAKE: code = ACK_ENTER;
            EV_MRET: code = ACK_RETURN;
            EV_CSR:  code = e.reenable ? ACK_REENABLE : ACK_IDLE;
            default: code = ACK_IDLE;
        endcase
        return code;
    endfunction

endpackage

// File: rtl/irq_evt_arbiter.sv
module irq_evt_arbiter
    import irq_entry_pkg::*;
(
    input  logic irq_req,
    input  logic mie,
    input  logic mret_fire,
    input  logic csr_write_mie,
    input  logic csr_mie_value,
    output evt_t evt
);
    always_comb begin
        evt.ev       = EV_NONE;
        evt.reenable = 1'b0;
        evt.new_mie  = csr_mie_value;
        if (irq_req && mie) begin
            evt.ev = EV_TAKE;
        end else if (mret_fire) begin
            evt.ev = EV_MRET;
        end else if (csr_write_mie) begin
            evt.ev       = EV_CSR;
            evt.reenable = !mie && csr_mie_value;
        end
    end
endmodule

// File: rtl/irq_status_regs.sv
module irq_status_regs
    import irq_entry_pkg::*;
#(
    parameter bit HAS_MMU = 1'b0
) (
    input  logic       clk,
    input  logic       rst,
    input  evt_t       evt,
    input  logic [1:0] priv_in,
    output logic       mie,
    output logic       mpie,
    output logic [1:0] mpp
);
    logic [1:0] mpp_src;

    assign mpp_src = HAS_MMU ? priv_in : PRIV_MACHINE;

    always_ff @(posedge clk) begin
        if (rst) begin
            mie  <= 1'b0;
            mpie <= 1'b0;
            mpp  <= PRIV_MACHINE;
        end else begin
            case (evt.ev)
                EV_TAKE: begin
                    mpie <= mie;
                    mie  <= 1'b0;
                    mpp  <= mpp_src;
                end
                EV_MRET: begin
                    mie  <= mpie;
                    mpie <= 1'b1;
                end
                EV_CSR: begin
                    mie <= evt.new_mie;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/irq_trap_regs.sv
module irq_trap_regs
    import irq_entry_pkg::*;
#(
    parameter int XLEN     = 32,
    parameter bit VECTORED = 1'b1
) (
    input  logic            clk,
    input  logic            rst,
    input  evt_t            evt,
    input  logic [XLEN-1:0] pc_in,
    output logic [XLEN-1:0] mepc,
    output logic [XLEN-1:0] mcause,
    output logic [XLEN-1:0] mtval,
    output logic            resv_clear
);
    localparam int PAD = XLEN - 1 - $bits(CAUSE_CODE_MEXT);
    localparam logic [XLEN-1:0] CAUSE_EXT = {1'b1, {PAD{1'b0}}, CAUSE_CODE_MEXT};

    always_ff @(posedge clk) begin
        if (rst) begin
            mepc       <= '0;
            mcause     <= '0;
            mtval      <= '0;
            resv_clear <= 1'b0;
        end else begin
            resv_clear <= (evt.ev == EV_TAKE);
            if (evt.ev == EV_TAKE) begin
                mepc  <= pc_in;
                mtval <= '0;
                if (!VECTORED) begin
                    mcause <= CAUSE_EXT;
                end
            end
        end
    end
endmodule

// File: rtl/irq_redirect_ack.sv
module irq_redirect_ack
    import irq_entry_pkg::*;
#(
    parameter int XLEN     = 32,
    parameter bit VECTORED = 1'b1
) (
    input  logic            clk,
    input  logic            rst,
    input  evt_t            evt,
    input  logic [XLEN-1:0] irq_handler_addr,
    input  logic [XLEN-1:0] mtvec_in,
    input  logic [XLEN-1:0] mepc,
    output logic            redirect_valid,
    output logic [XLEN-1:0] redirect_pc,
    output logic [1:0]      irq_ack
);
    logic [XLEN-1:0] entry_target;

    assign entry_target = VECTORED ? irq_handler_addr : mtvec_in;

    always_ff @(posedge clk) begin
        if (rst) begin
            redirect_valid <= 1'b0;
            redirect_pc    <= '0;
            irq_ack        <= ACK_IDLE;
        end else begin
            irq_ack        <= ack_for_event(evt);
            redirect_valid <= (evt.ev == EV_TAKE) || (evt.ev == EV_MRET);
            if (evt.ev == EV_TAKE) begin
                redirect_pc <= entry_target;
            end else if (evt.ev == EV_MRET) begin
                redirect_pc <= mepc;
            end
        end
    end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_entry_pkg::*;
#(
    parameter int XLEN     = 32,
    parameter bit VECTORED = 1'b1,
    parameter bit HAS_MMU  = 1'b0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            irq_req,
    input  logic [XLEN-1:0] irq_handler_addr,
    input  logic [XLEN-1:0] pc_in,
    input  logic [1:0]      priv_in,
    input  logic [XLEN-1:0] mtvec_in,
    input  logic            mret_fire,
    input  logic            csr_write_mie,
    input  logic            csr_mie_value,
    output logic            redirect_valid,
    output logic [XLEN-1:0] redirect_pc,
    output logic [1:0]      irq_ack,
    output logic            mie_o,
    output logic            mpie_o,
    output logic [1:0]      mpp_o,
    output logic [XLEN-1:0] mepc_o,
    output logic [XLEN-1:0] mcause_o,
    output logic [XLEN-1:0] mtval_o,
    output logic            resv_clear
);
    evt_t evt;

    irq_evt_arbiter u_arb (
        .irq_req       (irq_req),
        .mie           (mie_o),
        .mret_fire     (mret_fire),
        .csr_write_mie (csr_write_mie),
        .csr_mie_value (csr_mie_value),
        .evt           (evt)
    );

    irq_status_regs #(.HAS_MMU(HAS_MMU)) u_status (
        .clk     (clk),
        .rst     (rst),
        .evt     (evt),
        .priv_in (priv_in),
        .mie     (mie_o),
        .mpie    (mpie_o),
        .mpp     (mpp_o)
    );

    irq_trap_regs #(.XLEN(XLEN), .VECTORED(VECTORED)) u_trap (
        .clk        (clk),
        .rst        (rst),
        .evt        (evt),
        .pc_in      (pc_in),
        .mepc       (mepc_o),
        .mcause     (mcause_o),
        .mtval      (mtval_o),
        .resv_clear (resv_clear)
    );

    irq_redirect_ack #(.XLEN(XLEN), .VECTORED(VECTORED)) u_redir (
        .clk              (clk),
        .rst              (rst),
        .evt              (evt),
        .irq_handler_addr (irq_handler_addr),
        .mtvec_in         (mtvec_in),
        .mepc             (mepc_o),
        .redirect_valid   (redirect_valid),
        .redirect_pc      (redirect_pc),
        .irq_ack          (irq_ack)
    );
endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk #(
    parameter int XLEN     = 32,
    parameter bit VECTORED = 1'b1
) (
    input logic            clk,
    input logic            rst,
    input logic            irq_req,
    input logic [XLEN-1:0] irq_handler_addr,
    input logic [XLEN-1:0] pc_in,
    input logic [XLEN-1:0] mtvec_in,
    input logic            mret_fire,
    input logic            csr_write_mie,
    input logic            redirect_valid,
    input logic [XLEN-1:0] redirect_pc,
    input logic [1:0]      irq_ack,
    input logic            mie_o,
    input logic            mpie_o,
    input logic [XLEN-1:0] mepc_o
);
    logic take;
    assign take = irq_req && mie_o;

    AST_TAKE_ACK: assert property (@(posedge clk) disable iff (rst)
        take |=> (irq_ack == 2'b01 && redirect_valid && !mie_o)); // R7

    AST_ENTRY_MEPC: assert property (@(posedge clk) disable iff (rst)
        take |=> (mepc_o == $past(pc_in))); // R2

    AST_ENTRY_MPIE: assert property (@(posedge clk) disable iff (rst)
        take |=> mpie_o); // R5

    AST_NO_DOUBLE_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (irq_ack == 2'b01) |=> (irq_ack != 2'b01)); // R1

    AST_MRET_RETURN: assert property (@(posedge clk) disable iff (rst)
        (mret_fire && !take) |=> (irq_ack == 2'b10 && redirect_pc == $past(mepc_o) && mpie_o)); // R8

    AST_REENABLE_EDGE: assert property (@(posedge clk) disable iff (rst)
        (!take && !mret_fire && csr_write_mie && !mie_o) |=> (mie_o ? irq_ack == 2'b11 : irq_ack == 2'b00)); // R9

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!take && !mret_fire && !csr_write_mie) |=> (irq_ack == 2'b00 && !redirect_valid)); // R11

    generate
        if (VECTORED) begin : g_vec
            AST_VEC_TARGET: assert property (@(posedge clk) disable iff (rst)
                take |=> (redirect_pc == $past(irq_handler_addr))); // R3
        end else begin : g_tvec
            AST_TVEC_TARGET: assert property (@(posedge clk) disable iff (rst)
                take |=> (redirect_pc == $past(mtvec_in))); // R4
        end
    endgenerate
endmodule

bind irq_entry_seq irq_entry_seq_chk #(.XLEN(XLEN), .VECTORED(VECTORED)) u_chk (
    .clk              (clk),
    .rst              (rst),
    .irq_req          (irq_req),
    .irq_handler_addr (irq_handler_addr),
    .pc_in            (pc_in),
    .mtvec_in         (mtvec_in),
    .mret_fire        (mret_fire),
    .csr_write_mie    (csr_write_mie),
    .redirect_valid   (redirect_valid),
    .redirect_pc      (redirect_pc),
    .irq_ack          (irq_ack),
    .mie_o            (mie_o),
    .mpie_o           (mpie_o),
    .mepc_o           (mepc_o)
);

// File: tb/irq_entry_seq_bench.sv
`timescale 1ns/1ps
module irq_entry_seq_bench;
    localparam int XLEN = 32;
    localparam logic [31:0] MTVEC = 32'h0000_0100;
    localparam logic [31:0] CAUSE = 32'h8000_000B;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic        irq_req = 0, mret_fire = 0, csr_write_mie = 0, csr_mie_value = 0;
    logic [31:0] irq_handler_addr = 0, pc_in = 0;
    logic [1:0]  priv_in = 2'b11;

    logic        rv_v, rv_t, mie_v, mie_t, mpie_v, mpie_t, rc_v, rc_t;
    logic [31:0] rpc_v, rpc_t, mepc_v, mepc_t, mc_v, mc_t, mt_v, mt_t;
    logic [1:0]  ack_v, ack_t, mpp_v, mpp_t;

    irq_entry_seq #(.XLEN(XLEN), .VECTORED(1'b1), .HAS_MMU(1'b0)) u_irq_entry_seq (
        .clk(clk), .rst(rst), .irq_req(irq_req), .irq_handler_addr(irq_handler_addr),
        .pc_in(pc_in), .priv_in(priv_in), .mtvec_in(MTVEC), .mret_fire(mret_fire),
        .csr_write_mie(csr_write_mie), .csr_mie_value(csr_mie_value),
        .redirect_valid(rv_v), .redirect_pc(rpc_v), .irq_ack(ack_v), .mie_o(mie_v),
        .mpie_o(mpie_v), .mpp_o(mpp_v), .mepc_o(mepc_v), .mcause_o(mc_v),
        .mtval_o(mt_v), .resv_clear(rc_v));

    irq_entry_seq #(.XLEN(XLEN), .VECTORED(1'b0), .HAS_MMU(1'b1)) u_irq_entry_seq_tv (
        .clk(clk), .rst(rst), .irq_req(irq_req), .irq_handler_addr(irq_handler_addr),
        .pc_in(pc_in), .priv_in(priv_in), .mtvec_in(MTVEC), .mret_fire(mret_fire),
        .csr_write_mie(csr_write_mie), .csr_mie_value(csr_mie_value),
        .redirect_valid(rv_t), .redirect_pc(rpc_t), .irq_ack(ack_t), .mie_o(mie_t),
        .mpie_o(mpie_t), .mpp_o(mpp_t), .mepc_o(mepc_t), .mcause_o(mc_t),
        .mtval_o(mt_t), .resv_clear(rc_t));

    typedef struct {
        string       tag;
        logic [1:0]  ack;
        logic        rv;
        logic [31:0] rpc_v, rpc_t, mepc, mc_t;
        logic        mie, mpie, resv;
        logic [1:0]  mpp_t;
    } exp_t;

    exp_t exp_q[$];
    int checks = 0;
    int errors = 0;

    logic        m_mie = 0, m_mpie = 0;
    logic [31:0] m_mepc = 0, m_mc_t = 0;
    logic [1:0]  m_mpp_t = 2'b11;

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic step(string tag, logic req, logic [31:0] addr, logic [31:0] pc,
                        logic [1:0] priv, logic mret, logic csrw, logic csrv);
        exp_t e;
        logic take, mret_e, csr_e;
        @(negedge clk);
        irq_req = req; irq_handler_addr = addr; pc_in = pc; priv_in = priv;
        mret_fire = mret; csr_write_mie = csrw; csr_mie_value = csrv;
        take   = req && m_mie;
        mret_e = !take && mret;
        csr_e  = !take && !mret && csrw;
        e.tag   = tag;
        e.ack   = take ? 2'b01 : mret_e ? 2'b10 : (csr_e && !m_mie && csrv) ? 2'b11 : 2'b00;
        e.rv    = take || mret_e;
        e.rpc_v = take ? addr : m_mepc;
        e.rpc_t = take ? MTVEC : m_mepc;
        e.resv  = take;
        if (take) begin
            m_mpie = m_mie; m_mie = 1'b0; m_mepc = pc; m_mc_t = CAUSE; m_mpp_t = priv;
        end else if (mret_e) begin
            m_mie = m_mpie; m_mpie = 1'b1;
        end else if (csr_e) begin
            m_mie = csrv;
        end
        e.mie = m_mie; e.mpie = m_mpie; e.mepc = m_mepc; e.mc_t = m_mc_t; e.mpp_t = m_mpp_t;
        exp_q.push_back(e);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            #3;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                chk(e.tag, "ack_v", {30'd0, ack_v}, {30'd0, e.ack});
                chk(e.tag, "ack_t", {30'd0, ack_t}, {30'd0, e.ack});
                chk(e.tag, "redirect_valid", {31'd0, rv_v}, {31'd0, e.rv});
                chk(e.tag, "redirect_valid_t", {31'd0, rv_t}, {31'd0, e.rv});
                if (e.rv) begin
                    chk(e.tag, "redirect_pc_v", rpc_v, e.rpc_v);
                    chk(e.tag, "redirect_pc_t", rpc_t, e.rpc_t);
                end
                chk(e.tag, "mie", {31'd0, mie_v}, {31'd0, e.mie});
                chk(e.tag, "mie_t", {31'd0, mie_t}, {31'd0, e.mie});
                chk(e.tag, "mpie", {31'd0, mpie_v}, {31'd0, e.mpie});
                chk(e.tag, "mepc", mepc_v, e.mepc);
                chk(e.tag, "mepc_t", mepc_t, e.mepc);
                chk(e.tag, "mcause_v", mc_v, 32'd0);
                chk(e.tag, "mcause_t", mc_t, e.mc_t);
                chk(e.tag, "mtval", mt_v | mt_t, 32'd0);
                chk(e.tag, "resv_clear", {31'd0, rc_v}, {31'd0, e.resv});
                chk(e.tag, "mpp_v", {30'd0, mpp_v}, 32'd3);
                chk(e.tag, "mpp_t", {30'd0, mpp_t}, {30'd0, e.mpp_t});
            end
        end
    end

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R12 reset state
        chk("R12", "ack", {30'd0, ack_v}, 32'd0);
        chk("R12", "mie/mpie", {30'd0, mie_v, mpie_v}, 32'd0);
        chk("R12", "redirect_valid", {31'd0, rv_v}, 32'd0);
        chk("R12", "mepc", mepc_v, 32'd0);
        chk("R12", "mcause", mc_t, 32'd0);
        chk("R12", "mtval", mt_v, 32'd0);
        chk("R12", "mpp", {30'd0, mpp_t}, 32'd3);
        chk("R12", "resv_clear", {31'd0, rc_v}, 32'd0);

        step("R11", 0, 0, 0, 2'b11, 0, 0, 0);
        step("R8", 0, 0, 32'h40, 2'b11, 1, 0, 0);                // return right after reset, mpie 0
        step("R9", 0, 0, 0, 2'b11, 0, 1, 0);                     // clear while clear
        step("R1", 1, 32'hA000, 32'h1234, 2'b00, 0, 0, 0);       // request while disabled
        step("R9", 0, 0, 0, 2'b11, 0, 1, 1);                     // re-enable 0->1
        step("R2", 1, 32'hA100, 32'h2000, 2'b00, 0, 0, 0);       // entry
        step("R1", 1, 32'hA200, 32'h3000, 2'b01, 0, 0, 0);       // blocked while disabled
        step("R11", 0, 0, 0, 2'b11, 0, 0, 0);
        step("R8", 0, 0, 0, 2'b11, 1, 0, 0);                     // return restores enable
        step("R9", 0, 0, 0, 2'b11, 0, 1, 1);                     // set while already set
        step("R10", 1, 32'hB000, 32'h4400, 2'b01, 1, 1, 0);      // entry beats return and write
        step("R10", 0, 0, 0, 2'b11, 1, 1, 0);                    // return beats write
        step("R9", 0, 0, 0, 2'b11, 0, 1, 0);                     // clear
        step("R9", 1, 32'hC000, 32'h5000, 2'b00, 0, 1, 1);       // request ignored, write re-enables
        step("R7", 1, 32'hC400, 32'h5800, 2'b01, 0, 0, 0);       // entry right after re-enable
        step("R6", 0, 0, 0, 2'b11, 0, 0, 0);
        step("R8", 0, 0, 0, 2'b11, 1, 0, 0);
        step("R4", 1, 32'hD000, 32'h6000, 2'b11, 0, 0, 0);
        step("R3", 0, 0, 0, 2'b11, 0, 0, 0);
        step("R11", 0, 0, 0, 2'b11, 0, 0, 0);
        @(negedge clk);
        irq_req = 0; mret_fire = 0; csr_write_mie = 0;
        repeat (3) @(posedge clk);
        #4;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule